// File: doc/BRIEF.md
# Impulse Noise Blanker Trigger

This block decides when the audio path of an FM receiver must be frozen because an ignition or motor spike has arrived. Each clock it takes two unsigned millivolt magnitudes: the rectified high-pass signal and its smoothed envelope. It forms an adaptive threshold, compares the rectified value against envelope plus threshold, and on a hit starts a retriggerable hold pulse. That pulse drives the sample-and-hold that sits downstream.

The threshold has a programmable floor. Once the envelope climbs past a knee of 900 mV, a noise-driven line with a programmable slope takes over wherever it is higher than the floor. The hold length is one of four blank times in microseconds. It is converted to clock cycles through a clocks-per-microsecond parameter.

Top module: `nb_trigger`

## Requirements
- R1: `threshold_mv` with the envelope at or below the knee equals 65 - 5*`floor_code` mV, so code 0 gives 65 mV and code 7 gives 30 mV.
- R2: While `peak_mv` is at most 900, `threshold_mv` depends only on `floor_code`. `slope_code` has no effect on it.
- R3: Above the knee the noise line is floor((peak_mv-900)*G/1024), where G is 444, 376, 308 or 239 for `slope_code` 0..3. At 1500 mV this gives 260, 220, 180 and 140 mV. `threshold_mv` is the larger of this line and the floor.
- R4: `trigger` goes high on the clock edge after a cycle in which `rect_mv` is strictly greater than `peak_mv + threshold_mv` with `enable` high. Equality does not fire.
- R5: The sum of envelope and threshold saturates at full scale (4095 for 12 bits) and does not wrap, so a full-scale overflow never fires.
- R6: A trigger starts a hold pulse of exactly N cycles. N = H*CLK_PER_US/2, with H = 76, 51, 64 or 44 half-microseconds for `blank_code` 0..3 (38, 25.5, 32 and 22 us).
- R7: A trigger that arrives while a pulse is running reloads the full length, so the pulse ends N cycles after the last reload.
- R8: With `enable` low, `trigger` stays low, no pulse starts, and a running pulse ends on the next edge.
- R9: Synchronous active-low reset clears `trigger` and `hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Blanker enable |
| rect_mv | input | MAG_W | Rectified signal magnitude, mV |
| peak_mv | input | MAG_W | Envelope magnitude, mV |
| floor_code | input | 3 | Minimum threshold select |
| slope_code | input | 2 | Noise slope select |
| blank_code | input | 2 | Blank time select |
| threshold_mv | output | MAG_W | Current adaptive threshold, mV |
| trigger | output | 1 | Registered comparator hit |
| hold | output | 1 | Hold pulse to the sample-and-hold |

## Verification
The assertions assume two things about the inputs. First, the code inputs are steady across the edge on which a trigger is registered. Second, the magnitudes are plain unsigned codes that need no further range limiting. The stimulus respects both: every input changes only on the falling edge and is held for at least a full cycle. The length checks use a single-cycle burst of a large rectified value against a zero envelope, so the comparator fires on one edge only. Full-scale envelope values are applied only in the vectors meant to exercise saturation.

// File: rtl/nbt_pkg.sv
// Shared constants and code decoders for the noise blanker trigger.
// Assumes magnitudes are unsigned millivolt codes.
package nbt_pkg;
    localparam int unsigned KNEE_MV       = 900;
    localparam int unsigned FLOOR_TOP_MV  = 65;
    localparam int unsigned FLOOR_STEP_MV = 5;
    localparam int unsigned SLOPE_SHIFT   = 10;
    localparam int unsigned GAIN_W        = 9;
    localparam int unsigned NUM_BLANK     = 4;
    localparam int unsigned MAX_HALF_US   = 76;

    // Slope gain in 1/1024 units: reaches 260/220/180/140 mV at 600 mV over the knee
    function automatic logic [GAIN_W-1:0] slope_gain(input logic [1:0] code);
        case (code)
            2'd0:    return 9'd444;
            2'd1:    return 9'd376;
            2'd2:    return 9'd308;
            default: return 9'd239;
        endcase
    endfunction

    // Blank time in half microseconds per code
    function automatic int unsigned blank_half_us(input int unsigned code);
        case (code)
            0:       return 76;
            1:       return 51;
            2:       return 64;
            default: return 44;
        endcase
    endfunction
endpackage

// File: rtl/nbt_threshold.sv
// Adaptive threshold: the larger of a coded floor and a noise line that
// rises with the envelope above the knee. Purely combinational.
// Assumes MAG_W is large enough to hold KNEE_MV.
module nbt_threshold
    import nbt_pkg::*;
#(
    parameter int unsigned MAG_W = 12
) (
    input  logic [MAG_W-1:0] peak_i,
    input  logic [2:0]       floor_code_i,
    input  logic [1:0]       slope_code_i,
    output logic [MAG_W-1:0] thr_o
);
    localparam int unsigned PROD_W = MAG_W + GAIN_W;
    localparam logic [MAG_W-1:0] KNEE = MAG_W'(KNEE_MV);

    logic [MAG_W-1:0]  excess;
    logic [PROD_W-1:0] prod;
    logic [MAG_W-1:0]  rise;
    logic [MAG_W-1:0]  floor_mv;

    // Envelope distance above the knee, clamped at zero
    always_comb excess = (peak_i > KNEE) ? (peak_i - KNEE) : '0;

    // Noise line scaled by the selected slope
    always_comb begin
        prod = PROD_W'(excess) * PROD_W'(slope_gain(slope_code_i));
        rise = MAG_W'(prod >> SLOPE_SHIFT);
    end

    // Floor from the 3-bit code, 5 mV per step down from 65 mV
    always_comb floor_mv = MAG_W'(FLOOR_TOP_MV) - MAG_W'(FLOOR_STEP_MV) * MAG_W'(floor_code_i);

    // Pick the higher of floor and noise line
    always_comb thr_o = (rise > floor_mv) ? rise : floor_mv;
endmodule

// File: rtl/nbt_compare.sv
// Saturating envelope-plus-threshold sum and registered comparator.
// Assumes inputs are stable around the sampling edge.
module nbt_compare #(
    parameter int unsigned MAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [MAG_W-1:0] rect_i,
    input  logic [MAG_W-1:0] peak_i,
    input  logic [MAG_W-1:0] thr_i,
    output logic             trig_o
);
    logic [MAG_W:0]   sum_wide;
    logic [MAG_W-1:0] level;
    logic             hit;

    // Sum with one extra bit, then clamp to full scale
    always_comb begin
        sum_wide = {1'b0, peak_i} + {1'b0, thr_i};
        level    = sum_wide[MAG_W] ? '1 : sum_wide[MAG_W-1:0];
        hit      = en_i && (rect_i > level);
    end

    // Register the comparator result
    always_ff @(posedge clk) begin
        if (!rst_n) trig_o <= 1'b0;
        else        trig_o <= hit;
    end

    AST_TRIG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !trig_o); // R8
    AST_NO_WRAP_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ((MAG_W+1)'(peak_i) + (MAG_W+1)'(thr_i) > (MAG_W+1)'({MAG_W{1'b1}})) |=> !trig_o); // R5
    AST_EQUAL_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ((MAG_W+1)'(rect_i) <= (MAG_W+1)'(peak_i) + (MAG_W+1)'(thr_i)) |=> !trig_o); // R4
endmodule

// File: rtl/nbt_pulse.sv
// Retriggerable hold pulse. Length is picked per trigger from four blank
// times, converted to cycles with CLK_PER_US. Assumes CLK_PER_US is even or
// that truncation of half-microsecond lengths is acceptable.
module nbt_pulse
    import nbt_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       trig_i,
    input  logic [1:0] sel_i,
    output logic       hold_o
);
    localparam int unsigned MAX_LEN = MAX_HALF_US * CLK_PER_US / 2;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] len_tab [NUM_BLANK];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_sel;

    // Cycle length for each blank code
    for (genvar g = 0; g < NUM_BLANK; g++) begin : g_len
        assign len_tab[g] = CNT_W'(blank_half_us(g) * CLK_PER_US / 2);
    end

    // Length for the current selection
    always_comb len_sel = len_tab[sel_i];

    // Down counter: disable clears, trigger reloads, otherwise count down
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) cnt_q <= '0;
        else if (trig_i)     cnt_q <= len_sel;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    // Pulse is active while the counter runs
    always_comb hold_o = (cnt_q != '0);

    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && trig_i) |=> (cnt_q == $past(len_sel))); // R7
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !hold_o); // R8
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !trig_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
endmodule

// File: rtl/nb_trigger.sv
// Top of the impulse noise blanker trigger: threshold, comparator and
// hold pulse former. Assumes one magnitude sample per clock.
module nb_trigger
    import nbt_pkg::*;
#(
    parameter int unsigned MAG_W      = 12,
    parameter int unsigned CLK_PER_US = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [MAG_W-1:0] rect_mv,
    input  logic [MAG_W-1:0] peak_mv,
    input  logic [2:0]       floor_code,
    input  logic [1:0]       slope_code,
    input  logic [1:0]       blank_code,
    output logic [MAG_W-1:0] threshold_mv,
    output logic             trigger,
    output logic             hold
);
    nbt_threshold #(.MAG_W(MAG_W)) u_thr (
        .peak_i       (peak_mv),
        .floor_code_i (floor_code),
        .slope_code_i (slope_code),
        .thr_o        (threshold_mv)
    );

    nbt_compare #(.MAG_W(MAG_W)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (enable),
        .rect_i (rect_mv),
        .peak_i (peak_mv),
        .thr_i  (threshold_mv),
        .trig_o (trigger)
    );

    nbt_pulse #(.CLK_PER_US(CLK_PER_US)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (enable),
        .trig_i (trigger),
        .sel_i  (blank_code),
        .hold_o (hold)
    );

    AST_FLOOR_BELOW_KNEE: assert property (@(posedge clk) disable iff (!rst_n)
        (peak_mv <= MAG_W'(KNEE_MV)) |->
        (threshold_mv == MAG_W'(FLOOR_TOP_MV) - MAG_W'(FLOOR_STEP_MV) * MAG_W'(floor_code))); // R2
    AST_TRIG_STARTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && enable) |=> hold); // R6
endmodule

// File: tb/nb_trigger_tb.sv
module nb_trigger_tb;
    localparam int unsigned MAG_W = 12;
    localparam int unsigned CPU   = 4;
    localparam int NV = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic enable;
    logic [MAG_W-1:0] rect_mv, peak_mv, threshold_mv;
    logic [2:0] floor_code;
    logic [1:0] slope_code, blank_code;
    logic trigger, hold;

    int checks = 0;
    int errors = 0;
    int hold_cnt = 0;

    always #2 clk = ~clk;

    nb_trigger #(.MAG_W(MAG_W), .CLK_PER_US(CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rect_mv(rect_mv),
        .peak_mv(peak_mv), .floor_code(floor_code), .slope_code(slope_code),
        .blank_code(blank_code), .threshold_mv(threshold_mv),
        .trigger(trigger), .hold(hold)
    );

    // Count high hold samples
    always @(negedge clk) if (hold) hold_cnt++;

    // Vector: peak, floor, slope, rect, expected threshold, expected trigger
    localparam logic [41:0] VEC [NV] = '{
        {12'd500,  3'd0, 2'd0, 12'd566,  12'd65,   1'b1},
        {12'd500,  3'd0, 2'd3, 12'd565,  12'd65,   1'b0},
        {12'd900,  3'd7, 2'd0, 12'd931,  12'd30,   1'b1},
        {12'd1500, 3'd0, 2'd0, 12'd1760, 12'd260,  1'b0},
        {12'd1500, 3'd0, 2'd1, 12'd1721, 12'd220,  1'b1},
        {12'd1500, 3'd0, 2'd2, 12'd1681, 12'd180,  1'b1},
        {12'd1500, 3'd0, 2'd3, 12'd1640, 12'd140,  1'b0},
        {12'd1000, 3'd0, 2'd0, 12'd1066, 12'd65,   1'b1},
        {12'd1000, 3'd7, 2'd0, 12'd1043, 12'd43,   1'b0},
        {12'd4000, 3'd0, 2'd0, 12'd4095, 12'd1344, 1'b0},
        {12'd200,  3'd3, 2'd2, 12'd251,  12'd50,   1'b1},
        {12'd4095, 3'd0, 2'd3, 12'd4095, 12'd745,  1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_in();
        peak_mv = '0;
        rect_mv = 12'd4000;
        @(negedge clk);
        rect_mv = '0;
    endtask

    task automatic wait_end();
        while (!hold) @(negedge clk);
        while (hold) @(negedge clk);
        #1;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; rect_mv = '0; peak_mv = '0;
        floor_code = '0; slope_code = '0; blank_code = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset trigger", int'(trigger), 0);
        chk("R9 reset hold", int'(hold), 0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 threshold, R4 R5 trigger
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            {peak_mv, floor_code, slope_code, rect_mv} = VEC[i][41:13];
            #1;
            chk($sformatf("R1/R2/R3 threshold vec %0d", i), int'(threshold_mv), int'(VEC[i][12:1]));
            @(negedge clk);
            chk($sformatf("R4/R5 trigger vec %0d", i), int'(trigger), int'(VEC[i][0]));
        end

        rect_mv = '0; peak_mv = '0; floor_code = '0; slope_code = '0;
        repeat (200) @(negedge clk);
        hold_cnt = 0;

        // R6 length for every blank code
        for (int s = 0; s < 4; s++) begin
            int exp_len;
            case (s)
                0: exp_len = 76 * CPU / 2;
                1: exp_len = 51 * CPU / 2;
                2: exp_len = 64 * CPU / 2;
                default: exp_len = 44 * CPU / 2;
            endcase
            blank_code = 2'(s);
            pulse_in();
            wait_end();
            chk($sformatf("R6 length code %0d", s), hold_cnt, exp_len);
            hold_cnt = 0;
        end

        // R7 retrigger 40 cycles after the first hit
        blank_code = 2'd0;
        pulse_in();
        repeat (39) @(negedge clk);
        pulse_in();
        wait_end();
        chk("R7 retrigger total", hold_cnt, 40 + 76 * CPU / 2);
        hold_cnt = 0;

        // R8 disable cuts a running pulse and blocks new ones
        pulse_in();
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R8 disable ends pulse", int'(hold), 0);
        rect_mv = 12'd4000;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8 disabled trigger", int'(trigger), 0);
            chk("R8 disabled hold", int'(hold), 0);
        end
        rect_mv = '0;
        enable = 1'b1;
        repeat (3) @(negedge clk);

        // R9 reset in the middle of a pulse
        pulse_in();
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset mid pulse hold", int'(hold), 0);
        chk("R9 reset mid pulse trigger", int'(trigger), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule